// File: doc/BRIEF.md
# SPI Slave Byte Port with Overflow Detection

This block is the serial side of a synchronous serial port operating as a bus slave. An external master supplies the serial clock. On each byte the port shifts the master's data into a receive buffer and shifts a reply byte, preloaded by the host, out on `miso`. The serial clock, slave select and data input are brought into the system clock domain through synchronizers, and all shifting is done on edges detected there. The system clock must run at least four times faster than the serial clock.

The host sees a one-byte receive buffer with a full flag and a one-byte transmit register. The usual sequence is: wait for the full flag, read the byte, then write the next reply. The reply goes out on the master's next eight clocks. Two error flags report faults. The overflow flag is set when a byte lands while the buffer still holds an unread one. The collision flag is set when a host write arrives in the middle of a byte.

A four-bit mode code selects one of two slave variants. In one variant, slave select gates the port. In the other, slave select is ignored. Clock polarity and the transmit edge are configured while the port is disabled. Clearing the enable resets the port.

Top module: `spi_slave_port`

## Requirements
- R1: After reset, `full`, `ovf`, `wcol` and `miso` are all 0.
- R2: Data on `mosi` is captured MSB first, one bit per sample edge. After the eighth bit, `rd_data` holds the byte and `full` is 1. The sample edge is the edge that is not the transmit edge.
- R3: The byte written through `wr_stb`/`wr_data` is shifted out on `miso` MSB first. `cpol` gives the idle level of `sck`. With `cke`=0, each bit is driven on the idle-to-active edge. With `cke`=1, each bit is driven on the active-to-idle edge, and the MSB appears as soon as the write is made.
- R4: With mode code 4'b0100, the port shifts only while `ss_n` is low. Clocks given while `ss_n` is high leave `full` at 0.
- R5: With mode code 4'b0101, `ss_n` is ignored and bytes are received with `ss_n` high. With any other mode code, the port does not shift.
- R6: If `ss_n` rises in the middle of a byte in mode 4'b0100, the partial byte is discarded and the bit count restarts. `miso` keeps its last value, and the next full byte is received correctly.
- R7: If a byte completes while `full` is 1 and no read occurs in that cycle, `ovf` is set. The new byte is dropped and `rd_data` keeps the unread byte.
- R8: A pulse on `ovf_clr` clears `ovf` without touching `rd_data`.
- R9: A host write made while a byte is partly shifted sets `wcol` and is ignored, so the original reply finishes unchanged. A pulse on `wcol_clr` clears `wcol`.
- R10: A pulse on `rd_stb` clears `full`.
- R11: While `en` is 0, the port is held in reset: the flags are 0, the transmit register and `miso` are 0, and host writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable; 0 holds the port in reset |
| cpol | input | 1 | Idle level of the serial clock |
| cke | input | 1 | Transmit edge: 0 idle-to-active, 1 active-to-idle |
| mode | input | 4 | Slave mode code (4'b0100 gated, 4'b0101 free) |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| rd_stb | input | 1 | Host read strobe; consumes the buffered byte |
| rd_data | output | BITS | Received byte buffer |
| wr_stb | input | 1 | Host write strobe for the reply byte |
| wr_data | input | BITS | Reply byte |
| ovf_clr | input | 1 | Clears the overflow flag |
| wcol_clr | input | 1 | Clears the collision flag |
| full | output | 1 | Receive buffer holds an unread byte |
| ovf | output | 1 | Receive overflow flag |
| wcol | output | 1 | Write collision flag |

## Verification
The hardest states to reach from the ports are those that depend on where a byte stands when a host or select event arrives: a write collision, and a deselect in the middle of a byte. The bench reaches them by splitting one master transfer into two bit ranges and injecting the host write or the `ss_n` rise between them. The original reply must then still come back whole. Overflow is reached by running two transfers with no read between them. All these cases sit after a sweep over every polarity, transmit-edge and gating combination, with byte values generated arithmetically.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

  localparam logic [3:0] MODE_GATED = 4'b0100;
  localparam logic [3:0] MODE_FREE  = 4'b0101;

  typedef struct packed {
    logic sck;
    logic ss_n;
    logic mosi;
  } pins_t;

  localparam pins_t PINS_RST = '{sck: 1'b0, ss_n: 1'b1, mosi: 1'b0};

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int unsigned CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_n;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_n = d;
    end else begin : g_multi
      always_comb chain_n = {chain_q[CHAIN_W-W-1:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_n;
  end

  assign q = chain_q[CHAIN_W-1 -: W];

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            sel_ok,
  input  logic            cpol,
  input  logic            cke,
  input  logic            sck_s,
  input  logic            mosi_s,
  input  logic            ld,
  input  logic [BITS-1:0] ld_data,
  output logic            miso,
  output logic            done,
  output logic [BITS-1:0] done_byte,
  output logic            busy
);

  localparam int unsigned CNT_W = (BITS > 1) ? $clog2(BITS) : 1;
  localparam int unsigned RX_W  = BITS - 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  logic             sck_d;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [RX_W-1:0]  rx_q, rx_n;
  logic [BITS-1:0]  tx_q, tx_n;
  logic             miso_q, miso_n;
  logic             busy_q, busy_n;

  logic edge_any, lead, trail, samp, xmit, run;

  assign run      = en & sel_ok;
  assign edge_any = sck_s ^ sck_d;
  assign lead     = edge_any & (sck_s != cpol);
  assign trail    = edge_any & (sck_s == cpol);
  assign samp     = run & (cke ? lead : trail);
  assign xmit     = run & (cke ? trail : lead);

  assign done      = samp & (cnt_q == LAST);
  assign done_byte = {rx_q, mosi_s};

  always_comb begin
    cnt_n  = cnt_q;
    rx_n   = rx_q;
    tx_n   = tx_q;
    miso_n = miso_q;
    busy_n = busy_q;
    if (!en) begin
      cnt_n  = '0;
      rx_n   = '0;
      tx_n   = '0;
      miso_n = 1'b0;
      busy_n = 1'b0;
    end else if (!sel_ok) begin
      cnt_n  = '0;
      rx_n   = '0;
      busy_n = 1'b0;
    end else begin
      if (xmit && (!cke || cnt_q != '0)) begin
        miso_n = tx_q[BITS-1];
        tx_n   = {tx_q[BITS-2:0], 1'b0};
        if (!cke) busy_n = 1'b1;
      end
      if (samp) begin
        rx_n = {rx_q[RX_W-2:0], mosi_s};
        if (cnt_q == LAST) begin
          cnt_n  = '0;
          busy_n = 1'b0;
        end else begin
          cnt_n  = cnt_q + 1'b1;
          busy_n = 1'b1;
        end
      end
    end
    if (en && ld) begin
      if (cke) begin
        tx_n   = {ld_data[BITS-2:0], 1'b0};
        miso_n = ld_data[BITS-1];
      end else begin
        tx_n = ld_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      miso_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      sck_d  <= sck_s;
      cnt_q  <= cnt_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      miso_q <= miso_n;
      busy_q <= busy_n;
    end
  end

  assign miso = miso_q;
  assign busy = busy_q;

  // R4, R6: a deselected or disabled port restarts its bit count
  a_r4_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0 && !busy_q));

  // R6: miso keeps its value across a deselect
  a_r6_miso_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sel_ok && !ld) |=> $stable(miso_q));

  // R2: completions are never back to back
  a_r2_done_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: disabled port drives 0 on miso
  a_r11_miso_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !miso_q);

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            rd_stb,
  input  logic            wr_stb,
  input  logic            ovf_clr,
  input  logic            wcol_clr,
  input  logic            done,
  input  logic [BITS-1:0] done_byte,
  input  logic            busy,
  output logic            ld,
  output logic [BITS-1:0] rx_buf,
  output logic            full,
  output logic            ovf,
  output logic            wcol
);

  logic [BITS-1:0] buf_q, buf_n;
  logic            full_q, full_n;
  logic            ovf_q, ovf_n;
  logic            wcol_q, wcol_n;

  assign ld = en & wr_stb & ~busy;

  always_comb begin
    buf_n  = buf_q;
    full_n = full_q;
    ovf_n  = ovf_q;
    wcol_n = wcol_q;
    if (!en) begin
      buf_n  = '0;
      full_n = 1'b0;
      ovf_n  = 1'b0;
      wcol_n = 1'b0;
    end else begin
      if (rd_stb)   full_n = 1'b0;
      if (ovf_clr)  ovf_n  = 1'b0;
      if (wcol_clr) wcol_n = 1'b0;
      if (done) begin
        if (full_q && !rd_stb) begin
          ovf_n = 1'b1;
        end else begin
          buf_n  = done_byte;
          full_n = 1'b1;
        end
      end
      if (wr_stb && busy) wcol_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      buf_q  <= buf_n;
      full_q <= full_n;
      ovf_q  <= ovf_n;
      wcol_q <= wcol_n;
    end
  end

  assign rx_buf = buf_q;
  assign full   = full_q;
  assign ovf    = ovf_q;
  assign wcol   = wcol_q;

  // R7: a byte landing on a full buffer sets overflow and leaves the buffer alone
  a_r7_ovf_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
    (en && done && full_q && !rd_stb) |=> (ovf_q && $stable(buf_q)));

  // R9: a write during a byte raises the collision flag
  a_r9_wcol_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_stb && busy) |=> wcol_q);

  // R10: a read without a simultaneous completion empties the buffer
  a_r10_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_stb && !done) |=> !full_q);

  // R11: a disabled port holds all flags low
  a_r11_flags_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!full_q && !ovf_q && !wcol_q));

  // R2: the buffer only fills because a byte completed
  a_r2_full_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(done));

endmodule

// File: rtl/spi_slave_port.sv
module spi_slave_port
  import spi_slave_pkg::*;
#(
  parameter int unsigned BITS        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            cpol,
  input  logic            cke,
  input  logic [3:0]      mode,
  input  logic            sck,
  input  logic            ss_n,
  input  logic            mosi,
  output logic            miso,
  input  logic            rd_stb,
  output logic [BITS-1:0] rd_data,
  input  logic            wr_stb,
  input  logic [BITS-1:0] wr_data,
  input  logic            ovf_clr,
  input  logic            wcol_clr,
  output logic            full,
  output logic            ovf,
  output logic            wcol
);

  pins_t           raw, syn;
  logic            gated, free_run, sel_ok;
  logic            ld, done, busy;
  logic [BITS-1:0] done_byte;

  assign raw = '{sck: sck, ss_n: ss_n, mosi: mosi};

  spi_in_sync #(
    .W      ($bits(pins_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw),
    .q    (syn)
  );

  assign gated    = (mode == MODE_GATED);
  assign free_run = (mode == MODE_FREE);
  assign sel_ok   = free_run | (gated & ~syn.ss_n);

  spi_shift_core #(.BITS(BITS)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .sel_ok   (sel_ok),
    .cpol     (cpol),
    .cke      (cke),
    .sck_s    (syn.sck),
    .mosi_s   (syn.mosi),
    .ld       (ld),
    .ld_data  (wr_data),
    .miso     (miso),
    .done     (done),
    .done_byte(done_byte),
    .busy     (busy)
  );

  spi_host_regs #(.BITS(BITS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .ovf_clr  (ovf_clr),
    .wcol_clr (wcol_clr),
    .done     (done),
    .done_byte(done_byte),
    .busy     (busy),
    .ld       (ld),
    .rx_buf   (rd_data),
    .full     (full),
    .ovf      (ovf),
    .wcol     (wcol)
  );

endmodule

// File: tb/spi_slave_port_tb.sv
module spi_slave_port_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int WATCHDOG   = 150000;

  logic       clk, rst_n, en, cpol, cke;
  logic [3:0] mode;
  logic       sck, ss_n, mosi, miso;
  logic       rd_stb, wr_stb, ovf_clr, wcol_clr;
  logic [7:0] rd_data, wr_data;
  logic       full, ovf, wcol;

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;

  spi_slave_port dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cke(cke), .mode(mode),
    .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso),
    .rd_stb(rd_stb), .rd_data(rd_data), .wr_stb(wr_stb), .wr_data(wr_data),
    .ovf_clr(ovf_clr), .wcol_clr(wcol_clr), .full(full), .ovf(ovf), .wcol(wcol)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec = nvec + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] v);
    wr_data = v; wr_stb = 1'b1; tick(1); wr_stb = 1'b0;
  endtask

  task automatic host_read();
    rd_stb = 1'b1; tick(1); rd_stb = 1'b0;
  endtask

  task automatic pulse_ovf_clr();
    ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0;
  endtask

  task automatic pulse_wcol_clr();
    wcol_clr = 1'b1; tick(1); wcol_clr = 1'b0;
  endtask

  // master side: bits first..last of mo, MSB first; got collects miso
  task automatic xfer_bits(input logic [7:0] mo, input int first, input int last,
                           inout logic [7:0] got);
    for (int i = first; i <= last; i++) begin
      if (cke) begin
        mosi = mo[7-i];
        tick(HALF);
        got = {got[6:0], miso};
        sck = ~cpol;
        tick(HALF);
        sck = cpol;
      end else begin
        mosi = mo[7-i];
        sck = ~cpol;
        tick(HALF);
        got = {got[6:0], miso};
        sck = cpol;
        tick(HALF);
      end
    end
    tick(HALF);
  endtask

  task automatic configure(input logic p, input logic e, input logic [3:0] m);
    en = 1'b0;
    tick(1);
    cpol = p; cke = e; mode = m; sck = p;
    tick(6);
    en = 1'b1;
    tick(1);
  endtask

  initial begin
    logic [7:0] got, mo, rep;
    logic       held;
    rst_n = 1'b0; en = 1'b0; cpol = 1'b0; cke = 1'b0; mode = 4'b0100;
    sck = 1'b0; ss_n = 1'b1; mosi = 1'b0;
    rd_stb = 1'b0; wr_stb = 1'b0; wr_data = 8'h00; ovf_clr = 1'b0; wcol_clr = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    check("R1 full", {7'd0, full}, 8'd0);
    check("R1 ovf", {7'd0, ovf}, 8'd0);
    check("R1 wcol", {7'd0, wcol}, 8'd0);
    check("R1 miso", {7'd0, miso}, 8'd0);

    // sweep: polarity x transmit edge x gating mode
    for (int cfg = 0; cfg < 8; cfg++) begin
      configure(cfg[0], cfg[1], cfg[2] ? 4'b0101 : 4'b0100);
      ss_n = cfg[2] ? 1'b1 : 1'b0;   // R5: free mode runs with ss_n high
      tick(4);
      check("R11 re-enable full", {7'd0, full}, 8'd0);
      for (int k = 0; k < 6; k++) begin
        mo  = 8'((k * 53 + cfg * 17 + 9) & 255);
        rep = 8'((k * 29 + cfg * 71 + 200) & 255);
        host_write(rep);
        got = 8'h00;
        xfer_bits(mo, 0, 7, got);
        tick(4);
        check(cfg[2] ? "R3/R5 reply" : "R3 reply", got, rep);
        check(cfg[2] ? "R2/R5 rx byte" : "R2 rx byte", rd_data, mo);
        check("R2 full set", {7'd0, full}, 8'd1);
        check("R7 no ovf", {7'd0, ovf}, 8'd0);
        host_read();
        tick(1);
        check("R10 full cleared", {7'd0, full}, 8'd0);
      end
    end

    // gated mode, cpol 0, cke 0
    configure(1'b0, 1'b0, 4'b0100);
    ss_n = 1'b1;
    tick(4);
    got = 8'h00;
    xfer_bits(8'h6B, 0, 7, got);
    tick(4);
    check("R4 ss high ignored", {7'd0, full}, 8'd0);
    ss_n = 1'b0;
    tick(4);
    host_write(8'h4D);
    got = 8'h00;
    xfer_bits(8'h6B, 0, 7, got);
    tick(4);
    check("R4 selected rx", rd_data, 8'h6B);
    check("R4 selected reply", got, 8'h4D);
    host_read();

    // R6 deselect mid-byte
    host_write(8'hA5);
    got = 8'h00;
    xfer_bits(8'hFF, 0, 2, got);
    held = miso;
    check("R6 partial miso", {7'd0, held}, 8'd1);
    ss_n = 1'b1;
    tick(6);
    check("R6 miso held", {7'd0, miso}, {7'd0, held});
    check("R6 partial dropped", {7'd0, full}, 8'd0);
    ss_n = 1'b0;
    tick(4);
    host_write(8'h3C);
    check("R6 write accepted", {7'd0, wcol}, 8'd0);
    got = 8'h00;
    xfer_bits(8'h81, 0, 7, got);
    tick(4);
    check("R6 next rx", rd_data, 8'h81);
    check("R6 next reply", got, 8'h3C);
    host_read();

    // R7 / R8 overflow
    got = 8'h00;
    xfer_bits(8'h11, 0, 7, got);
    tick(4);
    xfer_bits(8'h22, 0, 7, got);
    tick(4);
    check("R7 ovf set", {7'd0, ovf}, 8'd1);
    check("R7 old byte kept", rd_data, 8'h11);
    check("R7 still full", {7'd0, full}, 8'd1);
    pulse_ovf_clr();
    tick(1);
    check("R8 ovf cleared", {7'd0, ovf}, 8'd0);
    check("R8 buffer intact", rd_data, 8'h11);
    host_read();

    // R9 write collision
    host_write(8'hC3);
    got = 8'h00;
    xfer_bits(8'h96, 0, 3, got);
    host_write(8'h5A);
    tick(1);
    check("R9 wcol set", {7'd0, wcol}, 8'd1);
    xfer_bits(8'h96, 4, 7, got);
    tick(4);
    check("R9 reply unchanged", got, 8'hC3);
    check("R9 rx byte", rd_data, 8'h96);
    pulse_wcol_clr();
    tick(1);
    check("R9 wcol cleared", {7'd0, wcol}, 8'd0);
    host_read();

    // R5 undefined mode code: no shifting
    configure(1'b0, 1'b0, 4'b0000);
    ss_n = 1'b0;
    tick(4);
    got = 8'h00;
    xfer_bits(8'hE7, 0, 7, got);
    tick(4);
    check("R5 other code idle", {7'd0, full}, 8'd0);

    // R11 disable resets, writes ignored
    configure(1'b0, 1'b0, 4'b0100);
    ss_n = 1'b0;
    tick(4);
    got = 8'h00;
    xfer_bits(8'h77, 0, 7, got);
    tick(4);
    xfer_bits(8'h78, 0, 7, got);
    tick(4);
    check("R11 pre full", {7'd0, full}, 8'd1);
    en = 1'b0;
    tick(2);
    check("R11 full cleared", {7'd0, full}, 8'd0);
    check("R11 ovf cleared", {7'd0, ovf}, 8'd0);
    check("R11 rx cleared", rd_data, 8'h00);
    host_write(8'hEE);
    tick(2);
    en = 1'b1;
    tick(2);
    got = 8'hFF;
    xfer_bits(8'h12, 0, 7, got);
    tick(4);
    check("R11 write ignored", got, 8'h00);
    check("R11 rx after enable", rd_data, 8'h12);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule